// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block lets a host read and program a small serial configuration EEPROM that stores 64 words of 16 bits. The host presents a one-cycle request carrying an operation code, a word address and write data. The block builds the serial frame, drives chip select, the serial clock and the outgoing data line, and samples the returning data line. When the operation is complete it raises a one-cycle done pulse. A read returns its word on a parallel output, which holds that word until the next read.

Each frame opens with a nine-bit header. Read, write and erase send a three-bit command followed by the six-bit address. Write-enable and write-disable send a five-bit command followed by four zero fill bits, so that every header has the same length. A write appends sixteen data bits. A read clocks one leading zero from the memory, discards it, and then captures sixteen data bits. After a write or an erase, chip select is dropped for a short gap and raised again. The block then watches the returning line until the memory reports that it is ready.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset, and in every cycle with no operation in progress, chip select, serial clock and busy are low, and done is low.
- R2: The serial clock spends exactly div_i+1 system cycles high and div_i+1 system cycles low.
- R3: The header is sent most significant bit first. Operation codes: op_i=0 read sends 110+addr, 1 write sends 101+addr, 2 erase sends 111+addr, 3 enable sends 10011 then 0000, 4 disable sends 10000 then 0000.
- R4: A write sends the 16 data bits, MSB first, immediately after the header.
- R5: A read discards the first returned bit after the header and presents the next 16 bits, MSB first, on rdata_o. rdata_o holds that word until the next read.
- R6: An erase leaves the addressed word all ones.
- R7: After a write or an erase, done is not raised until the memory data line reads high, with chip select reasserted after a gap.
- R8: A request made while busy is ignored and produces a one-cycle err_o pulse in the following cycle.
- R9: A request with op_i of 5, 6 or 7 starts nothing and produces a one-cycle err_o pulse in the following cycle.
- R10: The outgoing data line is stable while the serial clock is high, and the serial clock only toggles while chip select is high.
- R11: done_o is a single-cycle pulse, and busy_o is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Serial clock half period minus one, in system cycles |
| req_i | input | 1 | Request strobe, one cycle |
| op_i | input | 3 | Operation code |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Word to write |
| rdata_o | output | DATA_W | Last word read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, one cycle |
| err_o | output | 1 | Request rejected, one cycle |
| sclk_o | output | 1 | Serial clock to the memory |
| cs_o | output | 1 | Chip select to the memory, active high |
| sdo_o | output | 1 | Serial data to the memory |
| sdi_i | input | 1 | Serial data from the memory |

## Verification
The error pulse is registered, so it is due in the cycle after the rejected request. The bench checks it at the next falling edge and confirms that it is gone one cycle later. Done comes one cycle after the last falling serial clock edge of a frame, or one cycle after the ready level is seen during polling. The bench therefore waits for done, sampling on falling edges, and only then checks rdata_o, the memory model's contents, its idle state and the header it recorded. The clock phases are counted in system cycles at falling edges, and the sweeps cover all 64 addresses for writes and reads.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WEN   = 3'd3,
    OP_WDIS  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } st_e;
endpackage

// File: rtl/uwire_tick_gen.sv
module uwire_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uwire_frame_build.sv
module uwire_frame_build
  import uwire_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int HDR_W   = ADDR_W + 3,
  parameter int FRAME_W = HDR_W + DATA_W,
  parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic [2:0]         op_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o,
  output logic               rd_o,
  output logic               poll_o,
  output logic               valid_o
);
  localparam logic [ADDR_W-3:0] FILL = '0;

  always_comb begin
    frame_o = '0;
    nbits_o = CNT_W'(HDR_W);
    rd_o    = 1'b0;
    poll_o  = 1'b0;
    valid_o = 1'b1;
    case (op_i)
      OP_READ: begin
        frame_o = {3'b110, addr_i, {DATA_W{1'b0}}};
        nbits_o = CNT_W'(HDR_W + 1 + DATA_W);
        rd_o    = 1'b1;
      end
      OP_WRITE: begin
        frame_o = {3'b101, addr_i, data_i};
        nbits_o = CNT_W'(FRAME_W);
        poll_o  = 1'b1;
      end
      OP_ERASE: begin
        frame_o = {3'b111, addr_i, {DATA_W{1'b0}}};
        poll_o  = 1'b1;
      end
      OP_WEN:  frame_o = {5'b10011, FILL, {DATA_W{1'b0}}};
      OP_WDIS: frame_o = {5'b10000, FILL, {DATA_W{1'b0}}};
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              cs_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int HDR_W   = ADDR_W + 3;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CAP_FIRST = CNT_W'(HDR_W + 1);

  st_e                state_q;
  logic [FRAME_W-1:0] shreg_q, frame;
  logic [CNT_W-1:0]   nbits_q, bit_q, nbits;
  logic               rd_q, poll_q, rd, poll, valid;
  logic               sclk_q, cs_q, sdo_q, done_q, err_q, gap_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               tick;

  uwire_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q != ST_IDLE),
    .div_i (div_i),
    .tick_o(tick)
  );

  uwire_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .op_i   (op_i),
    .addr_i (addr_i),
    .data_i (wdata_i),
    .frame_o(frame),
    .nbits_o(nbits),
    .rd_o   (rd),
    .poll_o (poll),
    .valid_o(valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      nbits_q <= '0;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      poll_q  <= 1'b0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
      sdo_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      gap_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= req_i && ((state_q != ST_IDLE) || !valid);
      case (state_q)
        ST_IDLE: if (req_i && valid) begin
          state_q <= ST_SHIFT;
          shreg_q <= frame;
          sdo_q   <= frame[FRAME_W-1];
          nbits_q <= nbits;
          rd_q    <= rd;
          poll_q  <= poll;
          bit_q   <= '0;
          cs_q    <= 1'b1;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            // rising edge: memory output is valid here
            if (rd_q && bit_q >= CAP_FIRST) rdata_q <= {rdata_q[DATA_W-2:0], sdi_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == nbits_q - 1'b1) begin
              cs_q  <= 1'b0;
              sdo_q <= 1'b0;
              gap_q <= 1'b0;
              if (poll_q) state_q <= ST_GAP;
              else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              bit_q   <= bit_q + 1'b1;
              shreg_q <= shreg_q << 1;
              sdo_q   <= shreg_q[FRAME_W-2];
            end
          end
        end
        ST_GAP: if (tick) begin
          // two ticks deselected = one full serial clock period
          if (gap_q) begin
            cs_q    <= 1'b1;
            state_q <= ST_POLL;
          end
          gap_q <= 1'b1;
        end
        ST_POLL: if (tick && sdi_i) begin
          cs_q    <= 1'b0;
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign sclk_o  = sclk_q;
  assign cs_o    = cs_q;
  assign sdo_o   = sdo_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!cs_q && !sclk_q));
  p_sdo_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(sdo_q));
  p_sclk_in_cs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> cs_q);
  p_busy_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o) |=> err_q);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
  p_poll_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_POLL && state_q == ST_IDLE) |-> $past(sdi_i));
endmodule

// File: tb/tb_uwire_eeprom_ctrl.sv
module tb_uwire_eeprom_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = 8'd0;
  logic        req = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [5:0]  addr = 6'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, err_o, sclk_o, cs_o, sdo_o, sdi;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  uwire_eeprom_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .req_i(req), .op_i(op),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .sclk_o(sclk_o), .cs_o(cs_o),
    .sdo_o(sdo_o), .sdi_i(sdi)
  );

  // memory model
  logic [15:0] mem [64];
  logic        m_sclk_q, m_cs_q, m_wen;
  int          m_cnt, m_busy, m_frames;
  logic [8:0]  m_sh, m_hdr, m_last_hdr;
  logic [15:0] m_dsh;
  logic        m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'h0000;
      m_sclk_q <= 0; m_cs_q <= 0; m_wen <= 0; m_cnt <= 0; m_busy <= 0;
      m_frames <= 0; m_sh <= 0; m_hdr <= 0; m_last_hdr <= 0; m_dsh <= 0;
    end else begin
      m_sclk_q <= sclk_o;
      m_cs_q   <= cs_o;
      if (m_busy > 0) m_busy <= m_busy - 1;
      if (cs_o && sclk_o && !m_sclk_q) begin
        m_cnt <= m_cnt + 1;
        m_sh  <= {m_sh[7:0], sdo_o};
        if (m_cnt == 8) m_hdr <= {m_sh[7:0], sdo_o};
        if (m_cnt >= 9) m_dsh <= {m_dsh[14:0], sdo_o};
      end
      if (!cs_o && m_cs_q) begin
        m_cnt <= 0;
        if (m_cnt > 0) begin
          m_frames   <= m_frames + 1;
          m_last_hdr <= m_hdr;
          if (m_cnt == 9 && m_hdr == 9'b100110000) m_wen <= 1;
          if (m_cnt == 9 && m_hdr == 9'b100000000) m_wen <= 0;
          if (m_cnt == 9 && m_hdr[8:6] == 3'b111 && m_wen) begin
            mem[m_hdr[5:0]] <= 16'hFFFF; m_busy <= 150;
          end
          if (m_cnt == 25 && m_hdr[8:6] == 3'b101 && m_wen) begin
            mem[m_hdr[5:0]] <= m_dsh; m_busy <= 150;
          end
        end
      end
    end
  end

  assign m_rd = (m_cnt >= 9) && (m_hdr[8:6] == 3'b110);
  always_comb begin
    if (!cs_o) sdi = 1'b0;
    else if (m_busy > 0) sdi = 1'b0;
    else if (m_rd) sdi = (m_cnt == 9 || m_cnt > 25) ? 1'b0 : mem[m_hdr[5:0]][25 - m_cnt];
    else sdi = 1'b1;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [5:0] a, input logic [15:0] d);
    int n;
    @(negedge clk);
    req = 1; op = o; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    n = 0;
    while (!done_o && n < 6000) begin @(negedge clk); n++; end
    chk("R7 done reached", {31'd0, n < 6000}, 32'd1);
    chk("R7 memory ready at done", {31'd0, m_busy == 0}, 32'd1);
    chk("R11 busy low at done", {31'd0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, done_o}, 32'd0);
    chk("R1 idle quiet", {29'd0, cs_o, sclk_o, busy_o}, 32'd0);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0407) ^ 16'h5A3C;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", {27'd0, cs_o, sclk_o, busy_o, done_o, err_o}, 32'd0);

    run_op(3'd3, 6'd0, 16'd0);
    chk("R3 enable header", {23'd0, m_last_hdr}, {23'd0, 9'b100110000});

    for (int a = 0; a < 64; a++) begin
      run_op(3'd1, 6'(a), pat(a));
      chk("R3 write header", {23'd0, m_last_hdr}, {23'd0, 3'b101, 6'(a)});
      chk("R4 write data", {16'd0, mem[a]}, {16'd0, pat(a)});
    end
    for (int a = 0; a < 64; a++) begin
      run_op(3'd0, 6'(a), 16'd0);
      chk("R3 read header", {23'd0, m_last_hdr}, {23'd0, 3'b110, 6'(a)});
      chk("R5 read data", {16'd0, rdata_o}, {16'd0, pat(a)});
    end

    run_op(3'd2, 6'd5, 16'd0);
    chk("R3 erase header", {23'd0, m_last_hdr}, {23'd0, 3'b111, 6'd5});
    chk("R6 erased word", {16'd0, mem[5]}, 32'h0000FFFF);
    run_op(3'd0, 6'd5, 16'd0);
    chk("R6 erased readback", {16'd0, rdata_o}, 32'h0000FFFF);
    repeat (4) @(negedge clk);
    chk("R5 rdata held", {16'd0, rdata_o}, 32'h0000FFFF);

    // R8: request while busy
    begin
      int f0, n;
      f0 = m_frames;
      @(negedge clk); req = 1; op = 3'd1; addr = 6'd9; wdata = 16'hBEEF;
      @(negedge clk); req = 0;
      repeat (5) @(negedge clk);
      req = 1; op = 3'd2; addr = 6'd10;
      @(negedge clk); req = 0;
      chk("R8 err pulse", {31'd0, err_o}, 32'd1);
      @(negedge clk);
      chk("R8 err one cycle", {31'd0, err_o}, 32'd0);
      n = 0;
      while (!done_o && n < 6000) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
      chk("R8 single frame", 32'(m_frames - f0), 32'd1);
      chk("R8 word untouched", {16'd0, mem[10]}, {16'd0, pat(10)});
      chk("R4 accepted write", {16'd0, mem[9]}, 32'h0000BEEF);
    end

    // R9: invalid codes
    for (int c = 5; c < 8; c++) begin
      @(negedge clk); req = 1; op = 3'(c);
      @(negedge clk); req = 0;
      chk("R9 err on bad op", {31'd0, err_o}, 32'd1);
      chk("R9 no start", {30'd0, busy_o, cs_o}, 32'd0);
    end

    run_op(3'd4, 6'd0, 16'd0);
    chk("R3 disable header", {23'd0, m_last_hdr}, {23'd0, 9'b100000000});
    run_op(3'd1, 6'd7, 16'h1234);
    chk("R3 protected write ignored", {16'd0, mem[7]}, {16'd0, pat(7)});

    // R2: clock phases with div=3
    div = 8'd3;
    begin
      int h, l;
      @(negedge clk); req = 1; op = 3'd0; addr = 6'd3;
      @(negedge clk); req = 0;
      while (!sclk_o) @(negedge clk);
      h = 0; while (sclk_o) begin h++; @(negedge clk); end
      l = 0; while (!sclk_o) begin l++; @(negedge clk); end
      chk("R2 high phase", 32'(h), 32'd4);
      chk("R2 low phase", 32'(l), 32'd4);
      while (!done_o) @(negedge clk);
      chk("R5 read at div3", {16'd0, rdata_o}, {16'd0, pat(3)});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule